// File: doc/BRIEF.md
# SPI Register-Protocol Target Frame Decoder

This block is the device end of a four-byte-header SPI register protocol. While chip select is low it collects a header from the bus master. The header holds the transfer direction, a length of 1 to 64 bytes and a 24-bit register address. The block then moves the data bytes to or from a simple local register port. Before the data phase it can hold the master off with a flow-control bit. The last bit the target returns in the fourth header byte is 1 when the target is ready and 0 when it wants wait states. While stalled, the master keeps clocking filler bytes until one of them comes back with its last bit set to 1.

All logic runs on the system clock. SCLK, chip select and MOSI are brought in through synchronizers and oversampled. MOSI is taken on SCLK rising edges and MISO changes after falling edges, which is SPI mode 0. Data is MSB first. The local port issues one request per data byte and holds it until the port answers with ready. The address advances by one after each byte, except that a configured FIFO address is never advanced. Reads are prefetched one byte ahead.

Top module: `spi_reg_target`

## Requirements
- R1: Header byte 0 is decoded as bit 7 = direction (1 read, 0 write) and bits 5:0 = length minus one, so a frame moves 1 to 64 data bytes; a 64-byte write and a 64-byte read both complete.
- R2: Header bytes 1, 2 and 3 form the 24-bit start address, most significant byte first; the first data byte of a frame is accessed at that address.
- R3: The last bit the target returns in header byte 3 is the ready flag. For a write it is 1 when no earlier local write is still queued or outstanding, and 0 otherwise. For a read it is always 0.
- R4: Every bit the target returns in header bytes, other than that ready flag, is 0. After a 0 ready flag the target answers each further byte with a last bit of 0 until it is ready, then answers exactly one byte with last bit 1. For a read it is ready once the first data byte has come back from the port. The data phase starts with the next byte.
- R5: Read data is returned on MISO MSB first, changing after SCLK falling edges and valid at the next rising edge.
- R6: After each data byte the local address increments by one, unless the current address equals the FIFO address (default 0x000024), in which case every byte of the frame uses that address.
- R7: Each write data byte produces exactly one local write (reg_we = 1) carrying that byte.
- R8: Bytes clocked after the frame's length has been reached cause no local access and are answered with 0.
- R9: Chip select rising in the middle of a frame abandons it without any local access for incomplete bytes; the next frame is decoded from a fresh header, and a read left in flight by the abandoned frame never supplies data to a later frame.
- R10: A header whose byte 0 bit 6 is 0 is treated as invalid: the frame causes no local access and MISO stays 0 until chip select rises.
- R11: After reset, and whenever chip select is high, MISO is 0 and no local request is raised.
- R12: A local request keeps reg_req, reg_we, reg_addr and reg_wdata stable until reg_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the master, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_req | output | 1 | Local access request, held until reg_ready |
| reg_we | output | 1 | 1 for a local write, 0 for a local read |
| reg_addr | output | 24 | Local byte address |
| reg_wdata | output | 8 | Local write data byte |
| reg_rdata | input | 8 | Local read data byte, valid with reg_ready |
| reg_ready | input | 1 | Local port completes the current request |

## Verification
The bench attacks the flow-control choice from both sides. A slow port must stretch a read into several wait bytes; a design that set the flag early would return stale or zero data. A still-busy earlier write must force wait states on the next write frame; a design that ignored the port would overrun it. Boundary frames check the full 64-byte length, extra trailing bytes and invalid headers; an off-by-one length counter or a missing bit-6 check shows up as extra or missing local accesses. The bench also aborts frames in the header and in the middle of a read, then repeats the FIFO address. A prefetch that leaked across frames would return wrong bytes, and an incrementing FIFO pointer would spread data over neighbouring registers.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
   localparam int ADDR_W    = 24;
   localparam int LEN_W     = 6;
   localparam int HDR_BYTES = 4;
   localparam int HDR_LAST  = HDR_BYTES - 1;

   typedef enum logic [1:0] {
      FR_HDR,
      FR_WAIT,
      FR_DATA,
      FR_DONE
   } fr_state_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_tgt_sync needs at least two stages");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_tgt_frame.sv
module spi_tgt_frame
   import spi_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi_s,
   input  logic              go_ok,
   input  logic [7:0]        rd_byte,
   output logic              miso,
   output logic              cur_read,
   output logic              hdr_done,
   output logic [ADDR_W-1:0] hdr_addr,
   output logic              wr_stb,
   output logic [7:0]        wr_byte,
   output logic              rd_take,
   output logic              rd_more
);
   fr_state_e        st;
   logic [2:0]       bit_idx;
   logic [1:0]       hdr_cnt;
   logic [7:0]       rx_sr;
   logic [7:0]       tx_sr;
   logic [15:0]      addr_hi;
   logic             go_q;
   logic [LEN_W-1:0] len_m1;
   logic [LEN_W-1:0] dcnt;

   logic [7:0] rx_next;
   logic       byte_end;
   logic       flag_slot;
   logic       load_slot;

   assign rx_next   = {rx_sr[6:0], mosi_s};
   assign byte_end  = sclk_rise && (bit_idx == 3'd7);
   assign flag_slot = sclk_fall && (bit_idx == 3'd7) &&
                      ((st == FR_WAIT) || (st == FR_HDR && hdr_cnt == 2'(HDR_LAST)));
   assign load_slot = sclk_fall && (bit_idx == 3'd0);

   assign rd_take  = load_slot && (st == FR_DATA) && cur_read;
   assign rd_more  = (dcnt != len_m1);
   assign hdr_done = byte_end && (st == FR_HDR) && (hdr_cnt == 2'(HDR_LAST));
   assign hdr_addr = {addr_hi, rx_next};
   assign wr_stb   = byte_end && (st == FR_DATA) && !cur_read;
   assign wr_byte  = rx_next;
   assign miso     = tx_sr[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FR_HDR;
         bit_idx  <= '0;
         hdr_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         addr_hi  <= '0;
         go_q     <= 1'b0;
         len_m1   <= '0;
         dcnt     <= '0;
         cur_read <= 1'b0;
      end else if (!cs_act) begin
         st      <= FR_HDR;
         bit_idx <= '0;
         hdr_cnt <= '0;
         tx_sr   <= '0;
         go_q    <= 1'b0;
         dcnt    <= '0;
      end else begin
         if (sclk_rise) begin
            rx_sr   <= rx_next;
            bit_idx <= bit_idx + 3'd1;
         end
         if (byte_end) begin
            unique case (st)
               FR_HDR: begin
                  hdr_cnt <= hdr_cnt + 2'd1;
                  if (hdr_cnt == 2'd0) begin
                     cur_read <= rx_next[7];
                     len_m1   <= rx_next[LEN_W-1:0];
                     if (!rx_next[6]) st <= FR_DONE;
                  end else if (hdr_cnt != 2'(HDR_LAST)) begin
                     addr_hi <= {addr_hi[7:0], rx_next};
                  end else begin
                     st <= go_q ? FR_DATA : FR_WAIT;
                  end
               end
               FR_WAIT: if (go_q) st <= FR_DATA;
               FR_DATA: begin
                  dcnt <= dcnt + 1'b1;
                  if (dcnt == len_m1) st <= FR_DONE;
               end
               default: ;
            endcase
         end
         if (flag_slot) begin
            tx_sr <= {go_ok, 7'd0};
            go_q  <= go_ok;
         end else if (load_slot) begin
            tx_sr <= rd_take ? rd_byte : 8'h00;
         end else if (sclk_fall) begin
            tx_sr <= {tx_sr[6:0], 1'b0};
         end
      end
   end

   // R4: the data phase is only entered after a byte that carried a 1 flag
   assert_go_before_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_DATA && $past(st) != FR_DATA) |-> $past(go_q));

   // R8: the data counter never runs beyond the decoded length
   assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_DATA) |-> (dcnt <= len_m1));
endmodule

// File: rtl/spi_tgt_port.sv
module spi_tgt_port
   import spi_tgt_pkg::*;
#(
   parameter logic [ADDR_W-1:0] FIFO_ADDR = 24'h000024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_end,
   input  logic              cur_read,
   input  logic              hdr_done,
   input  logic [ADDR_W-1:0] hdr_addr,
   input  logic              wr_stb,
   input  logic [7:0]        wr_byte,
   input  logic              rd_take,
   input  logic              rd_more,
   output logic              go_ok,
   output logic [7:0]        rd_byte,
   output logic              reg_req,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   input  logic [7:0]        reg_rdata,
   input  logic              reg_ready
);
   function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
      return (a == FIFO_ADDR) ? a : a + ADDR_W'(1);
   endfunction

   logic [ADDR_W-1:0] ptr;
   logic              want, want_we;
   logic [ADDR_W-1:0] want_addr;
   logic [7:0]        want_data;
   logic              rd_valid, stale;
   logic              kill_rd;

   assign kill_rd = frame_end && want && !want_we;
   assign go_ok   = cur_read ? rd_valid : !(want || reg_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         want      <= 1'b0;
         want_we   <= 1'b0;
         want_addr <= '0;
         want_data <= '0;
         reg_req   <= 1'b0;
         reg_we    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         rd_byte   <= '0;
         rd_valid  <= 1'b0;
         stale     <= 1'b0;
      end else begin
         if (want && !reg_req && !kill_rd) begin
            reg_req   <= 1'b1;
            reg_we    <= want_we;
            reg_addr  <= want_addr;
            reg_wdata <= want_data;
            want      <= 1'b0;
         end
         if (reg_req && reg_ready) begin
            reg_req <= 1'b0;
            if (!reg_we) begin
               if (stale) stale <= 1'b0;
               else begin
                  rd_byte  <= reg_rdata;
                  rd_valid <= 1'b1;
               end
            end
         end
         if (hdr_done) begin
            if (cur_read) begin
               want      <= 1'b1;
               want_we   <= 1'b0;
               want_addr <= hdr_addr;
               ptr       <= step(hdr_addr);
            end else begin
               ptr <= hdr_addr;
            end
         end
         if (wr_stb) begin
            want      <= 1'b1;
            want_we   <= 1'b1;
            want_addr <= ptr;
            want_data <= wr_byte;
            ptr       <= step(ptr);
         end
         if (rd_take) begin
            rd_valid <= 1'b0;
            if (rd_more) begin
               want      <= 1'b1;
               want_we   <= 1'b0;
               want_addr <= ptr;
               ptr       <= step(ptr);
            end
         end
         if (frame_end) begin
            if (kill_rd) want <= 1'b0;
            rd_valid <= 1'b0;
            if (reg_req && !reg_we && !reg_ready) stale <= 1'b1;
         end
      end
   end

   // R12: an open request keeps its command fields until the port answers
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ready) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));

   // R3: no read data is left over when a read header completes, so reads stall
   assert_read_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_done && cur_read) |-> !rd_valid);

   // R7: a write byte never lands on top of a queued write byte
   assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !(want && want_we));
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
   import spi_tgt_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] FIFO_ADDR   = 24'h000024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              reg_req,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   input  logic [7:0]        reg_rdata,
   input  logic              reg_ready
);
   logic [2:0] pins_s;
   logic       cs_s, sclk_s, mosi_s;
   logic       cs_d, sclk_d;
   logic       cs_act, sclk_rise, sclk_fall, frame_end;

   spi_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_cs_n, spi_sclk, spi_mosi}),
      .q    (pins_s)
   );
   assign {cs_s, sclk_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
      end
   end

   assign cs_act    = !cs_s;
   assign sclk_rise = cs_act && sclk_s && !sclk_d;
   assign sclk_fall = cs_act && !sclk_s && sclk_d;
   assign frame_end = cs_s && !cs_d;

   logic              go_ok, cur_read, hdr_done, wr_stb, rd_take, rd_more;
   logic [7:0]        rd_byte, wr_byte;
   logic [ADDR_W-1:0] hdr_addr;

   spi_tgt_frame i_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .mosi_s   (mosi_s),
      .go_ok    (go_ok),
      .rd_byte  (rd_byte),
      .miso     (spi_miso),
      .cur_read (cur_read),
      .hdr_done (hdr_done),
      .hdr_addr (hdr_addr),
      .wr_stb   (wr_stb),
      .wr_byte  (wr_byte),
      .rd_take  (rd_take),
      .rd_more  (rd_more)
   );

   spi_tgt_port #(.FIFO_ADDR(FIFO_ADDR)) i_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_end(frame_end),
      .cur_read (cur_read),
      .hdr_done (hdr_done),
      .hdr_addr (hdr_addr),
      .wr_stb   (wr_stb),
      .wr_byte  (wr_byte),
      .rd_take  (rd_take),
      .rd_more  (rd_more),
      .go_ok    (go_ok),
      .rd_byte  (rd_byte),
      .reg_req  (reg_req),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .reg_ready(reg_ready)
   );

   // R11: with chip select settled high the target keeps MISO low
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && cs_d) |-> !spi_miso);
endmodule

// File: tb/test_spi_reg_target.sv
`timescale 1ns/1ps
module test_spi_reg_target;
   localparam int HALF = 8;
   localparam logic [23:0] FIFO_A = 24'h000024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        miso;
   logic        req, we, ready;
   logic [23:0] addr;
   logic [7:0]  wdata, rdata;

   always #2.5 clk = ~clk;

   spi_reg_target i_spi_reg_target (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .reg_req(req), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .reg_ready(ready)
   );

   // example register file with a FIFO location, for the bench only
   logic [7:0]  mem [256];
   logic [7:0]  fifo_log [64];
   int          acc_n, fifo_wr_n, fifo_rd_n, lat_cnt;
   int          lat = 1;
   logic [23:0] last_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 256; k++) mem[k] <= 8'(k) ^ 8'h5A;
         ready <= 1'b0; rdata <= '0; acc_n <= 0; lat_cnt <= 0;
         fifo_wr_n <= 0; fifo_rd_n <= 0; last_addr <= '0;
      end else if (req && !ready) begin
         if (lat_cnt >= lat) begin
            lat_cnt <= 0; ready <= 1'b1; acc_n <= acc_n + 1; last_addr <= addr;
            if (addr == FIFO_A) begin
               if (we) begin fifo_log[fifo_wr_n[5:0]] <= wdata; fifo_wr_n <= fifo_wr_n + 1; end
               else begin rdata <= 8'hC0 + 8'(fifo_rd_n); fifo_rd_n <= fifo_rd_n + 1; end
            end else if (we) mem[addr[7:0]] <= wdata;
            else rdata <= mem[addr[7:0]];
         end else lat_cnt <= lat_cnt + 1;
      end else ready <= 1'b0;
   end

   int n_chk = 0, n_fail = 0;
   logic [7:0] tx_buf [80];
   logic [7:0] rx_buf [80];
   int   waits;
   logic flag0, hdr_zero;

   function automatic logic [7:0] init_val(input int a);
      return 8'(a) ^ 8'h5A;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk); mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic cs_low();
      @(negedge clk); cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic cs_high();
      @(negedge clk); cs_n = 1'b1;
      repeat (30) @(negedge clk);
   endtask

   task automatic run_frame(input bit rd, input bit bad, input int len, input logic [23:0] a, input int nbytes);
      logic [7:0] r0, r1, r2, r3, r;
      cs_low();
      xfer_byte({rd, !bad, 6'(len - 1)}, r0);
      xfer_byte(a[23:16], r1);
      xfer_byte(a[15:8], r2);
      xfer_byte(a[7:0], r3);
      flag0    = r3[0];
      hdr_zero = (r0 == 0) && (r1 == 0) && (r2 == 0) && (r3[7:1] == 0);
      waits = 0;
      if (!bad) begin
         r = r3;
         while (!r[0] && waits < 64) begin
            xfer_byte(8'h00, r);
            waits++;
            if (r[7:1] != 0) hdr_zero = 1'b0;
         end
      end
      for (int i = 0; i < nbytes; i++) xfer_byte(tx_buf[i], rx_buf[i]);
      cs_high();
   endtask

   task automatic t_reset();
      chk(miso == 1'b0, "R11", "miso after reset", miso, 0);
      chk(req == 1'b0, "R11", "reg_req after reset", req, 0);
   endtask

   task automatic t_write_basic();
      int a0 = acc_n;
      tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
      run_frame(0, 0, 4, 24'h000010, 4);
      chk(flag0 == 1'b1, "R3", "write ready flag", flag0, 1);
      chk(waits == 0, "R3", "write wait bytes", waits, 0);
      chk(hdr_zero, "R4", "header filler bits", hdr_zero, 1);
      for (int i = 0; i < 4; i++)
         chk(mem[16 + i] == tx_buf[i], "R6", "write incr data", mem[16 + i], tx_buf[i]);
      chk(acc_n - a0 == 4, "R7", "one access per write byte", acc_n - a0, 4);
   endtask

   task automatic t_read_basic();
      run_frame(1, 0, 4, 24'h000010, 4);
      chk(flag0 == 1'b0, "R3", "read header flag", flag0, 0);
      chk(waits == 1, "R4", "read wait bytes fast port", waits, 1);
      chk(hdr_zero, "R4", "read filler bits", hdr_zero, 1);
      for (int i = 0; i < 4; i++)
         chk(rx_buf[i] == 8'h11 * (i + 1), "R5", "read data msb first", rx_buf[i], 8'h11 * (i + 1));
   endtask

   task automatic t_addr_order();
      tx_buf[0] = 8'h77;
      run_frame(0, 0, 1, 24'h123456, 1);
      chk(last_addr == 24'h123456, "R2", "address byte order", last_addr, 24'h123456);
      chk(mem[8'h56] == 8'h77, "R2", "write at start addr", mem[8'h56], 8'h77);
   endtask

   task automatic t_fifo();
      int w0 = fifo_wr_n, r0 = fifo_rd_n;
      tx_buf[0] = 8'hA1; tx_buf[1] = 8'hA2; tx_buf[2] = 8'hA3;
      run_frame(0, 0, 3, FIFO_A, 3);
      chk(fifo_wr_n - w0 == 3, "R6", "fifo write count", fifo_wr_n - w0, 3);
      for (int i = 0; i < 3; i++)
         chk(fifo_log[6'(w0 + i)] == tx_buf[i], "R6", "fifo write data", fifo_log[6'(w0 + i)], tx_buf[i]);
      chk(mem[8'h25] == init_val(8'h25), "R6", "no spill past fifo", mem[8'h25], init_val(8'h25));
      run_frame(1, 0, 3, FIFO_A, 3);
      for (int i = 0; i < 3; i++)
         chk(rx_buf[i] == 8'hC0 + 8'(r0 + i), "R6", "fifo read data", rx_buf[i], 8'hC0 + 8'(r0 + i));
   endtask

   task automatic t_len64();
      int a0 = acc_n, errs = 0;
      for (int i = 0; i < 64; i++) tx_buf[i] = 8'(i * 3 + 1);
      run_frame(0, 0, 64, 24'h000080, 64);
      run_frame(1, 0, 64, 24'h000080, 64);
      for (int i = 0; i < 64; i++) if (rx_buf[i] != tx_buf[i]) errs++;
      chk(errs == 0, "R1", "64-byte round trip mismatches", errs, 0);
      chk(acc_n - a0 == 128, "R1", "64-byte access count", acc_n - a0, 128);
   endtask

   task automatic t_extra();
      int a0 = acc_n;
      tx_buf[0] = 8'h9A; tx_buf[1] = 8'h9B; tx_buf[2] = 8'h9C; tx_buf[3] = 8'h9D;
      run_frame(0, 0, 2, 24'h000040, 4);
      chk(acc_n - a0 == 2, "R8", "extra write bytes ignored", acc_n - a0, 2);
      chk(mem[8'h41] == 8'h9B, "R8", "last counted byte", mem[8'h41], 8'h9B);
      chk(mem[8'h42] == init_val(8'h42), "R8", "byte past length", mem[8'h42], init_val(8'h42));
      a0 = acc_n;
      tx_buf[0] = 0; tx_buf[1] = 0; tx_buf[2] = 0;
      run_frame(1, 0, 1, 24'h000040, 3);
      chk(rx_buf[0] == 8'h9A, "R8", "single read byte", rx_buf[0], 8'h9A);
      chk(rx_buf[1] == 8'h00 && rx_buf[2] == 8'h00, "R8", "bytes after read length", {rx_buf[1], rx_buf[2]}, 0);
      chk(acc_n - a0 == 1, "R8", "no prefetch past length", acc_n - a0, 1);
   endtask

   task automatic t_abort();
      logic [7:0] r;
      int a0 = acc_n;
      cs_low();
      xfer_byte(8'h40, r);
      xfer_byte(8'h00, r);
      cs_high();
      tx_buf[0] = 8'h5C;
      run_frame(0, 0, 1, 24'h000030, 1);
      chk(flag0 == 1'b1, "R9", "fresh header after abort", flag0, 1);
      chk(mem[8'h30] == 8'h5C, "R9", "write after abort", mem[8'h30], 8'h5C);
      chk(acc_n - a0 == 1, "R9", "aborted header no access", acc_n - a0, 1);
      tx_buf[0] = 0; tx_buf[1] = 0;
      run_frame(1, 0, 4, 24'h000010, 1);
      run_frame(1, 0, 2, 24'h000012, 2);
      chk(rx_buf[0] == 8'h33 && rx_buf[1] == 8'h44, "R9", "read after aborted read",
          {rx_buf[0], rx_buf[1]}, 16'h3344);
   endtask

   task automatic t_bad_hdr();
      int a0 = acc_n;
      tx_buf[0] = 8'hEE;
      run_frame(0, 1, 1, 24'h000050, 1);
      chk(acc_n - a0 == 0, "R10", "invalid header access count", acc_n - a0, 0);
      chk(mem[8'h50] == init_val(8'h50), "R10", "invalid header no write", mem[8'h50], init_val(8'h50));
      chk(flag0 == 1'b0 && rx_buf[0] == 8'h00, "R10", "invalid header miso", {flag0, rx_buf[0]}, 0);
   endtask

   task automatic t_slow_read();
      lat = 300;
      tx_buf[0] = 0;
      run_frame(1, 0, 1, 24'h000010, 1);
      chk(waits >= 2, "R4", "slow port wait bytes", waits, 2);
      chk(rx_buf[0] == 8'h11, "R5", "slow port read data", rx_buf[0], 8'h11);
      lat = 1;
   endtask

   task automatic t_write_stall();
      lat = 1500;
      tx_buf[0] = 8'h61;
      run_frame(0, 0, 1, 24'h000020, 1);
      tx_buf[0] = 8'h62;
      run_frame(0, 0, 1, 24'h000021, 1);
      chk(flag0 == 1'b0, "R3", "busy port write flag", flag0, 0);
      chk(waits >= 1, "R3", "busy port wait bytes", waits, 1);
      repeat (2000) @(negedge clk);
      chk(mem[8'h20] == 8'h61 && mem[8'h21] == 8'h62, "R7", "both stalled writes",
          {mem[8'h20], mem[8'h21]}, 16'h6162);
      lat = 1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_basic();
      t_read_basic();
      t_addr_order();
      t_fifo();
      t_len64();
      t_extra();
      t_abort();
      t_bad_hdr();
      t_slow_read();
      t_write_stall();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule